// File: doc/BRIEF.md
# Dual-Channel Free-Running PWM Timer

This block generates two pulse-width-modulated outputs from one up-counter. The counter is `CNT_W` bits wide, 16 by default. It always runs through its whole range and then wraps, so the PWM period is fixed at 2^CNT_W counter ticks. A compare match never clears it. Each tick lasts a power-of-two number of input clocks, chosen by a 4-bit divider select. Each output has its own compare value, and that value sets the number of ticks per period for which the output is active. Duty is therefore compare / 2^CNT_W. A one-clock interrupt pulse marks every wrap of the counter to zero.

Software writes compare values into a shadow register with a per-channel write strobe. The working compare copies the shadow only when a period starts, so a period never mixes two widths. A compare of zero is forbidden: writing zero leaves the shadow unchanged and sets a sticky error flag, which only reset clears. One polarity input inverts both outputs.

A sequencer holds the run state. In `SEQ_IDLE` the counter and prescaler are held at zero. The transition *launch* (enable high) moves it to `SEQ_RUN`, and the transition *halt* (enable low) returns it to `SEQ_IDLE`. Each channel has its own two-state machine, `CH_OFF` and `CH_ON`. The transition *set* (on launch or on a counter wrap) moves it to `CH_ON`. The transition *clear* (on a compare match or on halt) moves it to `CH_OFF`.

Top module: `pwm_dual_timer`

## Requirements
- R1: The counter period is 2^CNT_W ticks. On the clock edge where the count wraps from all-ones to zero, `wrap_irq` goes high for exactly one clock. This happens every ratio × 2^CNT_W clocks after launch.
- R2: The divider select `div_sel` = s, for s from 0 to 8, makes one tick last 2^(MIN_SHIFT+s) input clocks. With the default MIN_SHIFT of 3, the ratios are 8 to 2048.
- R3: Select codes 9 to 15 give the same ratio as code 8.
- R4: With working compare N, the channel level is active during counter values 0 to N-1, which is N ticks. It becomes inactive on the edge where the count becomes N and active again on the wrap edge.
- R5: Channel 0 takes its width from `cmp0_val` and channel 1 from `cmp1_val`. The two channels are independent but share the same counter and period.
- R6: A non-zero write goes to the shadow register. It becomes the working compare only at the next launch or the next wrap, so the period in progress keeps its old width.
- R7: Writing zero to either channel leaves that channel's shadow unchanged and sets `cfg_err`. `cfg_err` stays at 1 until reset.
- R8: With `pol_inv` = 0, the active level on the pins is 1. With `pol_inv` = 1, both pins are inverted, so the inactive level is 1.
- R9: Dropping `en` stops the block at the next edge: the counter and prescaler clear, both levels go inactive and no interrupt is raised. Raising `en` again restarts from count 0, with both outputs active from the next edge.
- R10: After reset, both levels are inactive, `wrap_irq` and `cfg_err` are 0, and both shadows hold 2^(CNT_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| div_sel | input | 4 | Tick length select, 2^(MIN_SHIFT+code) clocks |
| cmp0_we | input | 1 | Write strobe for channel 0 compare |
| cmp0_val | input | CNT_W | Channel 0 compare value |
| cmp1_we | input | 1 | Write strobe for channel 1 compare |
| cmp1_val | input | CNT_W | Channel 1 compare value |
| pol_inv | input | 1 | Inverts both PWM pins when 1 |
| pwm0 | output | 1 | Channel 0 PWM output |
| pwm1 | output | 1 | Channel 1 PWM output |
| wrap_irq | output | 1 | One-clock pulse at each counter wrap |
| cfg_err | output | 1 | Sticky flag for a zero compare write |

## Verification
The embedded properties assume three things about the inputs: `div_sel` is changed only while the block is idle, a compare write never falls on the same edge as a wrap or a launch, and `en` stays low long enough for the idle state to be seen. The stimulus honours all three. It writes compares and changes the divider only while `en` is low, and it writes during a run only a few ticks after launch. It also keeps the polarity and zero-write cases apart from the divider sweep, so every mismatch points to one behaviour.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_ON  = 1'b1
    } ch_state_t;

endpackage

// File: rtl/pwm_tmr_prescale.sv
module pwm_tmr_prescale #(
    parameter int MIN_SHIFT  = 3,
    parameter int NUM_RATIOS = 9,
    parameter int SEL_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W  = MIN_SHIFT + NUM_RATIOS - 1;
    localparam int SPAN_W = PRE_W + 1;
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NUM_RATIOS - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [SEL_W-1:0]  sel_eff;
    logic [SPAN_W-1:0] span;
    logic [PRE_W-1:0]  mask;

    // Codes above the last ratio fold onto the slowest ratio.
    always_comb begin
        sel_eff = (sel > SEL_MAX) ? SEL_MAX : sel;
        span    = SPAN_W'(1) << (MIN_SHIFT + int'(sel_eff));
        mask    = PRE_W'(span - SPAN_W'(1));
        tick    = run && ((pre_q & mask) == mask);
    end

    // Free-running divider; it only needs the low bits that the mask selects.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (run)
            pre_q <= pre_q + 1'b1;
        else
            pre_q <= '0;
    end

    p_idle_clears_divider_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_q == '0));

endmodule

// File: rtl/pwm_tmr_sequencer.sv
module pwm_tmr_sequencer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    output logic             run,
    output logic             start_p,
    output logic             halt_p,
    output logic             step_p,
    output logic             wrap_p,
    output logic [CNT_W-1:0] cnt,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_d;
    end

    // launch: IDLE -> RUN on enable, halt: RUN -> IDLE when enable drops
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (en)  state_d = SEQ_RUN;
            SEQ_RUN:  if (!en) state_d = SEQ_IDLE;
            default:           state_d = SEQ_IDLE;
        endcase
    end

    always_comb begin
        run     = 1'b0;
        start_p = 1'b0;
        halt_p  = 1'b0;
        unique case (state_q)
            SEQ_IDLE: start_p = en;
            SEQ_RUN: begin
                run    = en;
                halt_p = !en;
            end
            default: ;
        endcase
        step_p = run && tick;
        wrap_p = step_p && (cnt == CNT_TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= wrap_p;
            if (!run)
                cnt <= '0;
            else if (step_p)
                cnt <= cnt + 1'b1;
        end
    end

    p_irq_single_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_count_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == '0));

    p_count_holds_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (cnt == $past(cnt)));

    p_idle_count_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE) |-> (cnt == '0));

endmodule

// File: rtl/pwm_tmr_channel.sv
module pwm_tmr_channel
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int INIT_CMP = 1 << (CNT_W - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             start_p,
    input  logic             wrap_p,
    input  logic             halt_p,
    input  logic             step_p,
    input  logic [CNT_W-1:0] cnt,
    output logic             level,
    output logic             err
);
    localparam logic [CNT_W-1:0] CMP_RESET = CNT_W'(INIT_CMP);

    ch_state_t        state_q, state_d;
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] active_q;
    logic             match;
    logic             zero_wr;

    assign zero_wr = wr_en && (wr_val == '0);
    assign match   = step_p && !wrap_p && (CNT_W'(cnt + 1'b1) == active_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_OFF;
        else
            state_q <= state_d;
    end

    // set: OFF -> ON at launch or wrap; clear: ON -> OFF at match or halt
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: if (start_p || wrap_p) state_d = CH_ON;
            CH_ON:  if (halt_p || match)   state_d = CH_OFF;
            default:                       state_d = CH_OFF;
        endcase
    end

    always_comb begin
        unique case (state_q)
            CH_ON:   level = 1'b1;
            default: level = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= CMP_RESET;
            active_q <= CMP_RESET;
            err      <= 1'b0;
        end else begin
            if (start_p || wrap_p)
                active_q <= shadow_q;
            if (zero_wr)
                err <= 1'b1;
            else if (wr_en)
                shadow_q <= wr_val;
        end
    end

    p_active_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        active_q != '0);

    p_zero_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr |=> $stable(shadow_q));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_wrap_turns_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_p |=> (state_q == CH_ON));

    p_halt_turns_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halt_p |=> (state_q == CH_OFF));

endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer #(
    parameter int CNT_W      = 16,
    parameter int SEL_W      = 4,
    parameter int MIN_SHIFT  = 3,
    parameter int NUM_RATIOS = 9,
    parameter int INIT_CMP   = 1 << (CNT_W - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             cmp0_we,
    input  logic [CNT_W-1:0] cmp0_val,
    input  logic             cmp1_we,
    input  logic [CNT_W-1:0] cmp1_val,
    input  logic             pol_inv,
    output logic             pwm0,
    output logic             pwm1,
    output logic             wrap_irq,
    output logic             cfg_err
);
    localparam int NUM_CH = 2;

    logic             tick, run, start_p, halt_p, step_p, wrap_p;
    logic [CNT_W-1:0] cnt;

    logic             ch_we    [NUM_CH];
    logic [CNT_W-1:0] ch_val   [NUM_CH];
    logic             ch_level [NUM_CH];
    logic             ch_err   [NUM_CH];

    assign ch_we[0]  = cmp0_we;
    assign ch_we[1]  = cmp1_we;
    assign ch_val[0] = cmp0_val;
    assign ch_val[1] = cmp1_val;

    pwm_tmr_prescale #(
        .MIN_SHIFT  (MIN_SHIFT),
        .NUM_RATIOS (NUM_RATIOS),
        .SEL_W      (SEL_W)
    ) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .sel   (div_sel),
        .tick  (tick)
    );

    pwm_tmr_sequencer #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .tick    (tick),
        .run     (run),
        .start_p (start_p),
        .halt_p  (halt_p),
        .step_p  (step_p),
        .wrap_p  (wrap_p),
        .cnt     (cnt),
        .irq     (wrap_irq)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_tmr_channel #(
            .CNT_W    (CNT_W),
            .INIT_CMP (INIT_CMP)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ch_we[c]),
            .wr_val  (ch_val[c]),
            .start_p (start_p),
            .wrap_p  (wrap_p),
            .halt_p  (halt_p),
            .step_p  (step_p),
            .cnt     (cnt),
            .level   (ch_level[c]),
            .err     (ch_err[c])
        );
    end

    assign pwm0    = ch_level[0] ^ pol_inv;
    assign pwm1    = ch_level[1] ^ pol_inv;
    assign cfg_err = ch_err[0] | ch_err[1];

    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wrap_irq) |=> !wrap_irq);

    p_both_on_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_irq |-> (ch_level[0] && ch_level[1]));

endmodule

// File: tb/pwm_dual_timer_test.sv
`timescale 1ns/1ps
module pwm_dual_timer_test;
    localparam int W = 4;
    localparam int P = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [3:0]   div_sel = 4'd0;
    logic         cmp0_we = 1'b0, cmp1_we = 1'b0;
    logic [W-1:0] cmp0_val = '0, cmp1_val = '0;
    logic         pol_inv = 1'b0;
    logic         pwm0, pwm1, wrap_irq, cfg_err;

    int nvec = 0;
    int nerr = 0;
    string cur_req = "R10";

    // reference state
    bit ref_run = 0;
    int ref_k = 0;
    int ref_n0 = 8, ref_n1 = 8;
    int ref_sh0 = 8, ref_sh1 = 8;
    bit ref_err = 0;
    int ratio = 1;

    pwm_dual_timer #(.CNT_W(W), .MIN_SHIFT(0)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel),
        .cmp0_we(cmp0_we), .cmp0_val(cmp0_val),
        .cmp1_we(cmp1_we), .cmp1_val(cmp1_val),
        .pol_inv(pol_inv), .pwm0(pwm0), .pwm1(pwm1),
        .wrap_irq(wrap_irq), .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what, input logic got, input logic exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s %s got %b expected %b (k=%0d ratio=%0d)", req, what, got, exp, ref_k, ratio);
        end
    endtask

    // One clock: compare at the falling edge, then advance the model at the rising edge.
    task automatic cyc();
        int tk;
        logic e0, e1, ei;
        @(negedge clk);
        tk = (ref_k / ratio) % P;
        e0 = (ref_run && tk < ref_n0) ^ pol_inv;
        e1 = (ref_run && tk < ref_n1) ^ pol_inv;
        ei = ref_run && ref_k > 0 && (ref_k % (ratio * P)) == 0;
        chk(cur_req, "pwm0", pwm0, e0);
        chk(cur_req, "pwm1", pwm1, e1);
        chk("R1", "wrap_irq", wrap_irq, ei);
        chk("R7", "cfg_err", cfg_err, ref_err);
        @(posedge clk);
        if (!ref_run && en) begin
            ref_run = 1; ref_k = 0; ref_n0 = ref_sh0; ref_n1 = ref_sh1;
        end else if (ref_run && !en) begin
            ref_run = 0;
        end else if (ref_run) begin
            ref_k++;
            if ((ref_k % (ratio * P)) == 0) begin
                ref_n0 = ref_sh0; ref_n1 = ref_sh1;
            end
        end
        if (cmp0_we) begin
            if (cmp0_val != 0) ref_sh0 = int'(cmp0_val); else ref_err = 1;
        end
        if (cmp1_we) begin
            if (cmp1_val != 0) ref_sh1 = int'(cmp1_val); else ref_err = 1;
        end
        #1;
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input int v0, input bit w0, input int v1, input bit w1);
        cmp0_we = w0; cmp0_val = W'(v0);
        cmp1_we = w1; cmp1_val = W'(v1);
        cyc();
        cmp0_we = 1'b0; cmp1_we = 1'b0;
    endtask

    task automatic set_div(input int s);
        div_sel = 4'(s);
        ratio = 1 << ((s > 8) ? 8 : s);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired, all requirements affected");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset state, shadows at half scale
        cur_req = "R10";
        run_n(2);
        en = 1'b1; run_n(P + 2);
        en = 1'b0; run_n(2);

        // R4: exhaustive width sweep at the fastest divider
        cur_req = "R4";
        set_div(0);
        for (int n = 1; n < P; n++) begin
            wr(n, 1, P - n, 1);
            en = 1'b1; run_n(2 * P + 3);
            en = 1'b0; run_n(1);
        end

        // R5: channels with different widths, shared period
        cur_req = "R5";
        set_div(2);
        wr(1, 1, P - 1, 1);
        en = 1'b1; run_n(2 * ratio * P + 3);
        en = 1'b0; run_n(1);

        // R2 / R3: every select code, one full period each
        for (int s = 0; s < 16; s++) begin
            cur_req = (s > 8) ? "R3" : "R2";
            set_div(s);
            wr(3, 1, 12, 1);
            en = 1'b1; run_n(ratio * P + 5);
            en = 1'b0; run_n(1);
        end

        // R6: write during a period takes effect only at the next wrap
        cur_req = "R6";
        set_div(1);
        wr(4, 1, 4, 1);
        en = 1'b1; run_n(10);
        wr(11, 1, 2, 1);
        run_n(2 * ratio * P + 3);
        en = 1'b0; run_n(1);

        // R8: inverted polarity on both pins
        cur_req = "R8";
        pol_inv = 1'b1;
        set_div(0);
        en = 1'b1; run_n(2 * P + 2);

        // R9: stop mid-period, stay idle, restart from zero
        cur_req = "R9";
        en = 1'b0; run_n(4);
        en = 1'b1; run_n(5);
        en = 1'b0; run_n(3);
        pol_inv = 1'b0;
        en = 1'b1; run_n(P + 3);

        // R7: zero writes, one while running and one while idle
        cur_req = "R7";
        wr(0, 0, 0, 1);
        run_n(2 * P + 2);
        en = 1'b0; run_n(1);
        wr(0, 1, 0, 0);
        en = 1'b1; run_n(P + 2);
        en = 1'b0; run_n(2);

        summary();
        $finish;
    end
endmodule